// File: doc/BRIEF.md
# Serial Line State Recognizer

This block watches a stream of received line symbols that have already been decoded. The symbols arrive two at a time, one symbol pair per valid strobe, and each pair comes with a class code. From the run of pair classes the block decides which line state the link is in. A static line state is taken only after a long enough run of like pairs: eight pairs for quiet, halt and master, and two pairs for the short idle state. A run of eight idle pairs promotes the short idle state to the long idle state. An active-start pair enters the active state at once. A stretch of pairs that never forms a valid run ends in the noise state.

The result is presented as a read-only 16-bit status word. The word carries a revision constant, the inverted signal-detect input, the last static state left, the current state, an active-mode bit, an unknown flag and the running pair count. A host or a link-management engine reads the word whenever it likes. All fields are registered, so every change appears one clock after the pair or input that caused it.

Top module: `line_state_recog`

## Requirements
- R1: After a synchronous reset the status word reads 16'hFC88 with the default revision: bits 15–11 revision, bit 10 inverted detect = 1, bits 9–8 previous state = 00, bits 7–5 current state = 100 (quiet), bit 4 = 0, bit 3 unknown flag = 1, bits 2–0 pair count = 0.
- R2: Bit 10 equals the inverse of `sig_det` as sampled at the previous rising clock edge, whether or not a pair is valid.
- R3: Bits 15–11 always hold the parameter `REV_ID` (default 5'b11111).
- R4: Pair classes are 0 quiet, 1 halt, 2 master, 3 idle, 4 active-start, 5 data, 6 and 7 other. A valid pair of class 0–3 that matches the previous valid pair's class raises the count by one, saturating at 7. Any other valid pair clears the count. A cycle without `pair_vld` changes no field except bit 10.
- R5: The eighth consecutive like pair of quiet, halt or master (count reaching 7) makes the current state 100, 110 or 101 respectively and clears the unknown flag.
- R6: The second consecutive idle pair (count 1) through the seventh make the current state 011 (short idle) with the flag cleared. The eighth and later (count 7) make it 111 (long idle).
- R7: A valid pair that does not commit a state sets the unknown flag, and the current state keeps its value. The exceptions are those covered by R8 and R9.
- R8: An active-start pair makes the current state 001 at once, with the flag and the count at 0. While in state 001 with the flag clear, data pairs keep the state and the flag.
- R9: If the unknown flag stays set across eight consecutive uncommitted valid pairs, counted from the pair that set it, the eighth pair makes the current state 000 (noise) and clears the flag. While in noise with the flag clear, pairs of class 4–7 other than active-start leave the state and the flag unchanged.
- R10: When the current state changes away from quiet, master, halt or long idle, bits 9–8 load 00, 01, 10 or 11 respectively. They change at no other time.
- R11: Bit 4 is 1 exactly when the current state is active (001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pair_vld | input | 1 | A symbol pair is presented this cycle |
| pair_cls | input | 3 | Class of the presented pair (encoding in R4) |
| sig_det | input | 1 | Signal detect from the receiver |
| status | output | 16 | Registered status word (layout in R1) |

## Verification
Every field of the status word comes from a register, so the effect of a pair presented at one rising edge is due right after that edge. Bit 10 follows `sig_det` with the same one-clock delay. The bench changes the inputs on the falling edge and steps its reference model at the rising edge. It compares all fields at the next falling edge, so each comparison lands on the cycle where the result is due. Directed sequences stop at the commit boundaries: the second idle pair, the eighth like pair and the eighth unknown pair. These stops pin the counts exactly where a count that is off by one would show.

// File: rtl/slr_pkg.sv
package slr_pkg;

    typedef enum logic [2:0] {
        CLS_QUIET     = 3'd0,
        CLS_HALT      = 3'd1,
        CLS_MASTER    = 3'd2,
        CLS_IDLE      = 3'd3,
        CLS_ACT_START = 3'd4,
        CLS_DATA      = 3'd5,
        CLS_OTHER     = 3'd6,
        CLS_RSVD      = 3'd7
    } pair_cls_e;

    typedef enum logic [2:0] {
        LS_NOISE  = 3'd0,
        LS_ACTIVE = 3'd1,
        LS_UNDEF  = 3'd2,
        LS_IDLE4  = 3'd3,
        LS_QUIET  = 3'd4,
        LS_MASTER = 3'd5,
        LS_HALT   = 3'd6,
        LS_IDLE16 = 3'd7
    } line_st_e;

    localparam int CNT_W = 3;

    typedef struct packed {
        logic [4:0]       rev;
        logic             sd_n;
        logic [1:0]       prev;
        line_st_e         cur;
        logic             act;
        logic             unkn;
        logic [CNT_W-1:0] cnt;
    } status_t;

    function automatic logic is_run_cls(input pair_cls_e c);
        return (c == CLS_QUIET) || (c == CLS_HALT) ||
               (c == CLS_MASTER) || (c == CLS_IDLE);
    endfunction

    function automatic line_st_e run_target(input pair_cls_e c);
        line_st_e t;
        case (c)
            CLS_HALT:   t = LS_HALT;
            CLS_MASTER: t = LS_MASTER;
            CLS_IDLE:   t = LS_IDLE16;
            default:    t = LS_QUIET;
        endcase
        return t;
    endfunction

    function automatic logic is_latched_st(input line_st_e s);
        logic [2:0] b;
        b = s;
        return b[2];
    endfunction

    function automatic logic [1:0] prev_code(input line_st_e s);
        logic [2:0] b;
        b = s;
        return b[1:0];
    endfunction

endpackage

// File: rtl/slr_run_track.sv
module slr_run_track
    import slr_pkg::*;
#(
    parameter int RUN_PAIRS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_vld,
    input  pair_cls_e        cls,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_PAIRS - 1);

    pair_cls_e        last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             like;

    assign like = is_run_cls(cls) && (cls == last_q);

    always_comb begin
        if (!like)
            cnt_nxt = '0;
        else if (cnt_q >= CNT_MAX)
            cnt_nxt = CNT_MAX;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= CLS_RSVD;
        end else if (pair_vld) begin
            cnt_q  <= cnt_nxt;
            last_q <= cls;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/slr_state.sv
module slr_state
    import slr_pkg::*;
#(
    parameter int RUN_PAIRS        = 8,
    parameter int IDLE_SHORT_PAIRS = 2,
    parameter int NOISE_PAIRS      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_vld,
    input  pair_cls_e        cls,
    input  logic [CNT_W-1:0] cnt_nxt,
    output line_st_e         cur,
    output logic [1:0]       prev,
    output logic             unkn
);
    localparam int UW = $clog2(NOISE_PAIRS + 1);

    line_st_e      cur_q, cur_n, tgt;
    logic [1:0]    prev_q;
    logic          unkn_q, unkn_n;
    logic [UW-1:0] ucnt_q, ucnt_n;
    logic          commit, go_unknown;

    always_comb begin
        cur_n      = cur_q;
        unkn_n     = unkn_q;
        ucnt_n     = ucnt_q;
        commit     = 1'b0;
        go_unknown = 1'b0;
        tgt        = cur_q;
        if (cls == CLS_ACT_START) begin
            commit = 1'b1;
            tgt    = LS_ACTIVE;
        end else if (cls == CLS_DATA && cur_q == LS_ACTIVE && !unkn_q) begin
            commit = 1'b0;
        end else if (is_run_cls(cls)) begin
            if (cls == CLS_IDLE) begin
                if (int'(cnt_nxt) >= RUN_PAIRS - 1) begin
                    commit = 1'b1;
                    tgt    = LS_IDLE16;
                end else if (int'(cnt_nxt) >= IDLE_SHORT_PAIRS - 1) begin
                    commit = 1'b1;
                    tgt    = LS_IDLE4;
                end else begin
                    go_unknown = 1'b1;
                end
            end else if (int'(cnt_nxt) == RUN_PAIRS - 1) begin
                commit = 1'b1;
                tgt    = run_target(cls);
            end else begin
                go_unknown = 1'b1;
            end
        end else if (!(cur_q == LS_NOISE && !unkn_q)) begin
            go_unknown = 1'b1;
        end

        if (commit) begin
            cur_n  = tgt;
            unkn_n = 1'b0;
            ucnt_n = '0;
        end else if (go_unknown) begin
            ucnt_n = unkn_q ? ucnt_q + 1'b1 : UW'(1);
            if (int'(ucnt_n) >= NOISE_PAIRS) begin
                cur_n  = LS_NOISE;
                unkn_n = 1'b0;
                ucnt_n = '0;
            end else begin
                unkn_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= LS_QUIET;
            prev_q <= 2'b00;
            unkn_q <= 1'b1;
            ucnt_q <= '0;
        end else if (pair_vld) begin
            if (cur_n != cur_q && is_latched_st(cur_q))
                prev_q <= prev_code(cur_q);
            cur_q  <= cur_n;
            unkn_q <= unkn_n;
            ucnt_q <= ucnt_n;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
    assign unkn = unkn_q;

endmodule

// File: rtl/slr_status_pack.sv
module slr_status_pack
    import slr_pkg::*;
#(
    parameter logic [4:0] REV_ID = 5'h1F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_det,
    input  line_st_e         cur,
    input  logic [1:0]       prev,
    input  logic             unkn,
    input  logic [CNT_W-1:0] cnt,
    output logic [15:0]      word
);
    logic    sd_n_q;
    status_t st;

    always_ff @(posedge clk) begin
        if (rst)
            sd_n_q <= 1'b1;
        else
            sd_n_q <= ~sig_det;
    end

    always_comb begin
        st.rev  = REV_ID;
        st.sd_n = sd_n_q;
        st.prev = prev;
        st.cur  = cur;
        st.act  = (cur == LS_ACTIVE);
        st.unkn = unkn;
        st.cnt  = cnt;
    end

    assign word = st;

endmodule

// File: rtl/line_state_recog.sv
module line_state_recog
    import slr_pkg::*;
#(
    parameter logic [4:0] REV_ID           = 5'h1F,
    parameter int         RUN_PAIRS        = 8,
    parameter int         IDLE_SHORT_PAIRS = 2,
    parameter int         NOISE_PAIRS      = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pair_vld,
    input  logic [2:0]  pair_cls,
    input  logic        sig_det,
    output logic [15:0] status
);
    pair_cls_e        cls;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    line_st_e         cur;
    logic [1:0]       prev;
    logic             unkn;

    assign cls = pair_cls_e'(pair_cls);

    slr_run_track #(.RUN_PAIRS(RUN_PAIRS)) u_run (
        .clk     (clk),
        .rst     (rst),
        .pair_vld(pair_vld),
        .cls     (cls),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    slr_state #(
        .RUN_PAIRS       (RUN_PAIRS),
        .IDLE_SHORT_PAIRS(IDLE_SHORT_PAIRS),
        .NOISE_PAIRS     (NOISE_PAIRS)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .pair_vld(pair_vld),
        .cls     (cls),
        .cnt_nxt (cnt_nxt),
        .cur     (cur),
        .prev    (prev),
        .unkn    (unkn)
    );

    slr_status_pack #(.REV_ID(REV_ID)) u_pack (
        .clk    (clk),
        .rst    (rst),
        .sig_det(sig_det),
        .cur    (cur),
        .prev   (prev),
        .unkn   (unkn),
        .cnt    (cnt),
        .word   (status)
    );

endmodule

// File: rtl/slr_chk.sv
module slr_chk #(
    parameter int IDLE_SHORT_PAIRS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        pair_vld,
    input logic [2:0]  pair_cls,
    input logic        sig_det,
    input logic [15:0] status
);
    localparam logic [2:0] SHORT_CNT = 3'(IDLE_SHORT_PAIRS - 1);

    // R2
    sd_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> status[10] == !$past(sig_det));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_vld |=> $stable(status[9:0]));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> (status[2:0] == 3'd0) ||
                     (status[2:0] == $past(status[2:0]) + 3'd1) ||
                     (status[2:0] == 3'd7 && $past(status[2:0]) == 3'd7));

    // R8
    active_entry_chk: assert property (@(posedge clk) disable iff (rst)
        pair_vld && pair_cls == 3'd4 |=>
            status[7:5] == 3'b001 && !status[3] && status[2:0] == 3'd0);

    // R5
    long_run_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (status[7:5] != $past(status[7:5])) && status[7] |->
            status[2:0] == 3'd7 && !status[3]);

    // R6
    short_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (status[7:5] != $past(status[7:5])) && status[7:5] == 3'b011 |->
            status[2:0] == SHORT_CNT && !status[3]);

    // R10
    prev_load_chk: assert property (@(posedge clk) disable iff (rst)
        (status[9:8] != $past(status[9:8])) |->
            $past(status[7]) && status[7:5] != $past(status[7:5]));

endmodule

bind line_state_recog slr_chk #(.IDLE_SHORT_PAIRS(IDLE_SHORT_PAIRS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pair_vld(pair_vld),
    .pair_cls(pair_cls),
    .sig_det (sig_det),
    .status  (status)
);

// File: tb/line_state_recog_bench.sv
module line_state_recog_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] REV = 5'h1F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pair_vld = 1'b0;
    logic [2:0]  pair_cls = 3'd0;
    logic        sig_det = 1'b0;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cur, m_prev, m_ulen, m_sdn;
    bit m_unk;
    int hist[$];

    line_state_recog u_line_state_recog (
        .clk(clk), .rst(rst), .pair_vld(pair_vld),
        .pair_cls(pair_cls), .sig_det(sig_det), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int run_len();
        int n = 0;
        for (int i = hist.size() - 1; i >= 0; i--) begin
            if (hist[i] <= 3 && hist[i] == hist[hist.size()-1]) n++;
            else break;
        end
        if (n == 0) return 0;
        return (n - 1 > 7) ? 7 : n - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cur = 4; m_prev = 0; m_ulen = 0; m_unk = 1'b1; m_sdn = 1;
        hist.delete();
    endtask

    task automatic unknown_step();
        m_ulen = m_unk ? m_ulen + 1 : 1;
        m_unk = 1'b1;
        if (m_ulen == 8) begin
            m_cur = 0; m_unk = 1'b0; m_ulen = 0;
        end
    endtask

    task automatic model_pair(input int c);
        int old = m_cur;
        int r, tgt;
        hist.push_back(c);
        if (hist.size() > 10) void'(hist.pop_front());
        r = run_len();
        if (c == 4) begin
            m_cur = 1; m_unk = 1'b0; m_ulen = 0;
        end else if (c == 5 && m_cur == 1 && !m_unk) begin
            m_cur = 1;
        end else if (c <= 3) begin
            tgt = -1;
            if (c == 3) tgt = (r >= 7) ? 7 : ((r >= 1) ? 3 : -1);
            else if (r == 7) tgt = (c == 0) ? 4 : ((c == 1) ? 6 : 5);
            if (tgt >= 0) begin
                m_cur = tgt; m_unk = 1'b0; m_ulen = 0;
            end else unknown_step();
        end else if (!(m_cur == 0 && !m_unk)) begin
            unknown_step();
        end
        if (m_cur != old && old >= 4) m_prev = old - 4;
    endtask

    task automatic compare_all();
        chk("R3 revision", status[15:11], REV);
        chk("R2 detect", status[10], m_sdn);
        chk("R10 previous", status[9:8], m_prev);
        chk("R5 R6 R7 R8 R9 current", status[7:5], m_cur);
        chk("R11 active bit", status[4], (m_cur == 1) ? 1 : 0);
        chk("R7 unknown", status[3], m_unk);
        chk("R4 count", status[2:0], run_len());
    endtask

    task automatic tick(input bit vld, input int c, input bit sd);
        pair_vld = vld; pair_cls = 3'(c); sig_det = sd;
        @(posedge clk);
        if (rst) model_reset();
        else begin
            m_sdn = sd ? 0 : 1;
            if (vld) model_pair(c);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic pairs(input int c, input int n);
        for (int i = 0; i < n; i++) tick(1'b1, c, 1'b1);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fork
            begin
                repeat (190000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: actual running expected finished");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int cls_r, len_r;
        model_reset();
        @(negedge clk);
        tick(1'b0, 0, 1'b0);
        tick(1'b0, 0, 1'b0);
        rst = 1'b0;
        // R1 reset word
        chk("R1 reset word", status, 16'hFC88);
        tick(1'b0, 0, 1'b0);
        chk("R2 detect low", status[10], 1);
        // R5 halt run
        pairs(1, 7);
        chk("R5 halt not yet", status[7:5], 4);
        chk("R7 flag during run", status[3], 1);
        pairs(1, 1);
        chk("R5 halt committed", status[7:5], 6);
        chk("R10 prev from quiet", status[9:8], 0);
        tick(1'b0, 3, 1'b1);
        chk("R4 gap holds count", status[2:0], 7);
        // R6 idle
        pairs(3, 2);
        chk("R6 short idle", status[7:5], 3);
        chk("R10 prev from halt", status[9:8], 2);
        pairs(3, 6);
        chk("R6 long idle", status[7:5], 7);
        pairs(3, 3);
        chk("R4 saturate", status[2:0], 7);
        // R7 break then master
        pairs(2, 1);
        chk("R7 state held", status[7:5], 7);
        chk("R7 flag set", status[3], 1);
        pairs(2, 7);
        chk("R5 master", status[7:5], 5);
        chk("R10 prev from long idle", status[9:8], 3);
        // R8 active
        pairs(4, 1);
        chk("R8 active", status[7:5], 1);
        chk("R10 prev from master", status[9:8], 1);
        chk("R11 active bit", status[4], 1);
        pairs(5, 4);
        chk("R8 data keeps", status[3], 0);
        // R9 noise
        pairs(6, 7);
        chk("R9 not yet noise", status[7:5], 1);
        pairs(7, 1);
        chk("R9 noise", status[7:5], 0);
        chk("R10 active not latched", status[9:8], 1);
        pairs(6, 3);
        chk("R9 noise flag clear", status[3], 0);
        pairs(0, 8);
        chk("R5 quiet", status[7:5], 4);
        chk("R10 noise not latched", status[9:8], 1);
        // mixed stream
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cls_r = lfsr[2:0];
            len_r = 1 + int'(lfsr[7:4]) % 11;
            for (int j = 0; j < len_r; j++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tick(lfsr[2:0] != 3'd0, cls_r, lfsr[5]);
            end
        end
        rst = 1'b1;
        tick(1'b1, 2, 1'b1);
        rst = 1'b0;
        chk("R1 reset again", status, 16'hFC88);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule